// File: doc/BRIEF.md
# Lookup-Table Bitwise Logic Unit

This unit computes each output bit independently. It takes the bits at the same position in its operands, packs them into a small index, and reads one entry from a truth table. With a table of eight entries any three-input Boolean function can be applied to a whole 64-bit word in one step. A four-entry table does the same for any two-input function. The table can come from an 8-bit immediate, from either nibble of a register operand, or from a 4-bit condition field. This lets software pick the logic function at run time, not only at compile time.

There are two further modes that work on narrow 4-bit condition fields. Each result bit in these modes is written only where a per-bit write mask allows it. Masked-off bits keep the old destination field. The logic itself is combinational. One register stage sits behind it: a result and its valid flag appear one clock after the operands are presented with `in_valid` high.

Top module: `lut_logic_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises, until the first accepted operation, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. When `in_valid` is low at a clock edge, `result` keeps its previous value whatever the other inputs do.
- R3: Mode 3'd0 (word ternary): result bit i = `imm[{dst[i], opa[i], opb[i]}]`. The index is LSB-first, so `dst` is index bit 2 and `opb` is index bit 0. The old destination word `dst` serves as the third input.
- R4: Mode 3'd1 (word binary, register table) with `nib_hi`=0: the table is `opc[3:0]`, and result bit i = `table[{opa[i], opb[i]}]`.
- R5: Mode 3'd1 with `nib_hi`=1: the table is `opc[7:4]`. The index is formed in the same way as in R4.
- R6: Mode 3'd2 (word binary, field table): the table is `cond_tab[3:0]`, and result bit i = `cond_tab[{opa[i], opb[i]}]`.
- R7: Mode 3'd3 (field ternary): the computed bit k (k = 0..3) is `imm[{cf_c[k], cf_b[k], cf_a[k]}]`.
- R8: Mode 3'd4 (field binary): the table is `cf_c`, and the computed bit k is `cf_c[{cf_a[k], cf_b[k]}]`.
- R9: In modes 3'd3 and 3'd4, `result[k]` takes the computed bit where `cf_mask[k]`=1 and `cf_dst[k]` where `cf_mask[k]`=0. `result[63:4]` is zero.
- R10: Modes 3'd5 to 3'd7 are reserved and produce an all-zero result with `out_valid` still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| mode | input | 3 | Operation select (see R3 to R10) |
| opa | input | 64 | Word operand A (index bit 1 in word modes) |
| opb | input | 64 | Word operand B (index bit 0 in word modes) |
| opc | input | 64 | Word operand C; its low byte holds the two nibble tables |
| dst | input | 64 | Old destination word, third input in word ternary mode |
| imm | input | 8 | Eight-entry truth table for the ternary modes |
| nib_hi | input | 1 | Selects `opc[7:4]` instead of `opc[3:0]` |
| cond_tab | input | 4 | Condition field used as the table in mode 3'd2 |
| cf_a | input | 4 | Field operand A |
| cf_b | input | 4 | Field operand B |
| cf_c | input | 4 | Field operand C (third input, or the table in mode 3'd4) |
| cf_dst | input | 4 | Old destination field |
| cf_mask | input | 4 | Per-bit write mask for the field modes |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered result |

## Verification
Every result is due exactly one rising edge after the operands are sampled with `in_valid` high. `out_valid` follows on the same edge. The bench applies each operation on a falling edge and compares on the next falling edge, so every comparison sees exactly one register update and never races the edge that loads it. For the hold case, the bench drives `in_valid` low and changes the other inputs. It then compares one falling edge later against the value expected from the previous operation.

// File: rtl/lut_logic_unit.sv
module lut_logic_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      mode,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] opc,
  input  logic [XLEN-1:0] dst,
  input  logic [7:0]      imm,
  input  logic            nib_hi,
  input  logic [3:0]      cond_tab,
  input  logic [3:0]      cf_a,
  input  logic [3:0]      cf_b,
  input  logic [3:0]      cf_c,
  input  logic [3:0]      cf_dst,
  input  logic [3:0]      cf_mask,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);
  localparam int CFW = 4;
  localparam logic [2:0] M_TERN   = 3'd0;
  localparam logic [2:0] M_BREG   = 3'd1;
  localparam logic [2:0] M_BFLD   = 3'd2;
  localparam logic [2:0] M_FTERN  = 3'd3;
  localparam logic [2:0] M_FBIN   = 3'd4;

  logic [3:0]      word_tab;
  logic [XLEN-1:0] tern_w, bin_w;
  logic [CFW-1:0]  ft3, ft2, fsel, fmerged;
  logic [XLEN-1:0] nxt;

  assign word_tab = (mode == M_BFLD) ? cond_tab : (nib_hi ? opc[7:4] : opc[3:0]);

  for (genvar i = 0; i < XLEN; i++) begin : g_word
    assign tern_w[i] = imm[{dst[i], opa[i], opb[i]}];
    assign bin_w[i]  = word_tab[{opa[i], opb[i]}];
  end

  for (genvar k = 0; k < CFW; k++) begin : g_fld
    assign ft3[k] = imm[{cf_c[k], cf_b[k], cf_a[k]}];
    assign ft2[k] = cf_c[{cf_a[k], cf_b[k]}];
  end

  assign fsel    = (mode == M_FTERN) ? ft3 : ft2;
  assign fmerged = (fsel & cf_mask) | (cf_dst & ~cf_mask);

  always_comb begin
    case (mode)
      M_TERN:          nxt = tern_w;
      M_BREG, M_BFLD:  nxt = bin_w;
      M_FTERN, M_FBIN: nxt = {{(XLEN-CFW){1'b0}}, fmerged};
      default:         nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R9
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == M_FTERN || mode == M_FBIN)) |=>
      ((result[CFW-1:0] & ~$past(cf_mask)) == ($past(cf_dst) & ~$past(cf_mask))));

  // R9
  field_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == M_FTERN || mode == M_FBIN)) |=> (result[XLEN-1:CFW] == '0));

  // R3
  tern_select_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == M_TERN && imm == 8'hCC) |=> (result == $past(opa)));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode > M_FBIN) |=> (result == '0));
endmodule

// File: tb/lut_logic_unit_test.sv
`timescale 1ns/1ps
module lut_logic_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [63:0] opa, opb, opc, dst;
  logic [7:0]  imm;
  logic        nib_hi;
  logic [3:0]  cond_tab, cf_a, cf_b, cf_c, cf_dst, cf_mask;
  logic        out_valid;
  logic [63:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] last_exp = '0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  lut_logic_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .opa(opa), .opb(opb), .opc(opc), .dst(dst), .imm(imm), .nib_hi(nib_hi),
    .cond_tab(cond_tab), .cf_a(cf_a), .cf_b(cf_b), .cf_c(cf_c),
    .cf_dst(cf_dst), .cf_mask(cf_mask), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic [63:0] model();
    logic [63:0] r = '0;
    logic [3:0]  t;
    int          idx;
    case (mode)
      3'd0: for (int i = 0; i < 64; i++) begin
        idx = dst[i] * 4 + opa[i] * 2 + opb[i];
        r[i] = imm[idx];
      end
      3'd1, 3'd2: begin
        t = (mode == 3'd2) ? cond_tab : (nib_hi ? opc[7:4] : opc[3:0]);
        for (int i = 0; i < 64; i++) begin
          idx = opa[i] * 2 + opb[i];
          r[i] = t[idx];
        end
      end
      3'd3, 3'd4: for (int k = 0; k < 4; k++) begin
        if (!cf_mask[k]) r[k] = cf_dst[k];
        else if (mode == 3'd3) begin
          idx = cf_c[k] * 4 + cf_b[k] * 2 + cf_a[k];
          r[k] = imm[idx];
        end else begin
          idx = cf_a[k] * 2 + cf_b[k];
          r[k] = cf_c[idx];
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", req, mode, act, exp);
    end
  endtask

  task automatic run_op(input string req);
    logic [63:0] e;
    in_valid = 1'b1;
    e = model();
    @(negedge clk);
    check(req, result, e);
    check({req, "_valid"}, {63'd0, out_valid}, 64'd1);
    last_exp = e;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = '0; opa = '0; opb = '0; opc = '0;
    dst = '0; imm = '0; nib_hi = 1'b0; cond_tab = '0; cf_a = '0; cf_b = '0;
    cf_c = '0; cf_dst = '0; cf_mask = '0;
    repeat (3) @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", result, 64'd0);

    // R3: every table over structured and random words
    mode = 3'd0;
    for (int t = 0; t < 256; t++) begin
      imm = t[7:0];
      opb = {16{4'h5}}; opa = {16{4'h3}}; dst = {8{8'h0F}};
      run_op("R3");
      opa = rnd(); opb = rnd(); dst = rnd();
      run_op("R3");
    end

    // R4 / R5: the unselected nibble is the complement
    mode = 3'd1;
    for (int t = 0; t < 16; t++) begin
      for (int h = 0; h < 2; h++) begin
        nib_hi = h[0];
        opc = rnd();
        opc[7:0] = h[0] ? {t[3:0], ~t[3:0]} : {~t[3:0], t[3:0]};
        opa = {16{4'h3}}; opb = {16{4'h5}};
        run_op(h[0] ? "R5" : "R4");
        opa = rnd(); opb = rnd();
        run_op(h[0] ? "R5" : "R4");
      end
    end

    // R6
    mode = 3'd2; nib_hi = 1'b0;
    for (int t = 0; t < 16; t++) begin
      cond_tab = t[3:0];
      opc = {64{1'b1}} ^ {60'd0, t[3:0]};
      opa = rnd(); opb = rnd();
      run_op("R6");
    end

    // R7 / R9
    mode = 3'd3;
    for (int t = 0; t < 256; t++) begin
      for (int m = 0; m < 16; m++) begin
        imm = t[7:0]; cf_mask = m[3:0];
        {cf_a, cf_b, cf_c, cf_dst} = rnd();
        opa = rnd(); dst = rnd();
        run_op("R7_R9");
      end
    end

    // R8 / R9
    mode = 3'd4;
    for (int t = 0; t < 16; t++)
      for (int m = 0; m < 16; m++)
        for (int a = 0; a < 16; a++) begin
          cf_c = t[3:0]; cf_mask = m[3:0]; cf_a = a[3:0];
          cf_b = ~a[3:0] ^ t[3:0]; cf_dst = a[3:0] ^ m[3:0];
          run_op("R8_R9");
        end

    // R10
    for (int md = 5; md < 8; md++) begin
      mode = md[2:0];
      opa = rnd(); opb = rnd(); opc = rnd(); dst = rnd(); imm = 8'hFF;
      cond_tab = 4'hF; cf_c = 4'hF; cf_mask = 4'hF; cf_dst = 4'hF;
      run_op("R10");
    end

    // R2: idle cycles leave the result alone
    mode = 3'd0; imm = 8'hE8;
    opa = rnd(); opb = rnd(); dst = rnd();
    run_op("R2");
    for (int n = 0; n < 4; n++) begin
      in_valid = 1'b0;
      mode = 3'd0; imm = ~imm; opa = rnd(); opb = rnd(); dst = rnd();
      @(negedge clk);
      check("R2", result, last_exp);
      check("R2", {63'd0, out_valid}, 64'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule